// File: doc/BRIEF.md
# Multi-phase SPI transfer sequencer

This block is the master engine of an SPI port. A single start pulse launches one transaction. The transaction is built from write, dummy and read phases, and a 3-bit mode code chooses which phases run and in what order. Write bytes come from a transmit byte stream that uses a valid/ready handshake. Every byte taken in during a read phase is handed to a receive byte stream as a one-cycle valid strobe. The engine generates SCK, MOSI and an active-low chip select, and it samples MISO.

Three byte counts are latched when the transaction starts: write, read and dummy. A count value of N stands for N+1 units. The clock divider, CPOL and CPHA are latched at the same moment. While the transaction runs, `busy` is high. At the end, `xfer_done` pulses once. If a write byte is due and the transmit stream has none ready, the engine holds SCK still and sets a sticky underrun flag.

Top module: `spi_phase_seq`

## Requirements
- R1: The phase order for each mode code is as follows. 0 is one full-duplex phase. 1 is write. 2 is read. 3 is write then read. 4 is read then write. 5 is write, dummy, read. 6 is read, dummy, write. 7 is receive.
- R2: A count of N moves N+1 units. Write and full-duplex phases use `wr_cnt`, read and receive phases use `rd_cnt`, and dummy phases use `dmy_cnt`. One unit is 8 SCK cycles, which is 16 edges. A dummy unit sends 0x00 and produces no receive strobe.
- R3: Each byte is shifted MSB first. The full-duplex phase sends transmit bytes and returns the same number of received bytes.
- R4: Read phases of modes 2 to 6 send 0x00 on MOSI. The receive phase of mode 7 sends 0xFF.
- R5: When no transaction is running, SCK sits at the CPOL level. Between the two edges of one SCK cycle there are exactly `div`+1 clocks.
- R6: With CPHA=0, MISO is sampled on odd edges, and MOSI holds steady from the preceding even edge. With CPHA=1, MOSI changes on odd edges and MISO is sampled on even edges.
- R7: The first SCK edge comes `div`+2 clocks after `cs_n` falls, provided there is no stall. `cs_n` rises `div`+1 clocks after the last edge.
- R8: `busy` is high from the clock after `start` until the end of the transaction. `xfer_done` is a single-cycle pulse in the first cycle with `busy` low.
- R9: A `start` received while `busy` is high has no effect.
- R10: When a write byte is due and `tx_valid` is low, SCK stays idle and `tx_underrun` goes high. The flag stays set until the next accepted start, and the transferred data is not affected.
- R11: After reset, `cs_n`=1, `busy`=0, `sck`=0, `mosi`=0, `tx_ready`=0, `rx_valid`=0 and `tx_underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | trigger pulse, taken only when idle |
| mode | input | 3 | phase order code |
| wr_cnt | input | CNT_W | write / full-duplex count, value N means N+1 bytes |
| rd_cnt | input | CNT_W | read / receive count, value N means N+1 bytes |
| dmy_cnt | input | DMY_W | dummy count, value N means N+1 units of 8 SCK cycles |
| div | input | DIV_W | SCK half-period is div+1 clocks |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | sampling edge select |
| tx_valid | input | 1 | transmit byte available |
| tx_data | input | BYTE_W | transmit byte |
| tx_ready | output | 1 | transmit byte taken this cycle when valid |
| rx_valid | output | 1 | received byte strobe |
| rx_data | output | BYTE_W | received byte |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| cs_n | output | 1 | active-low chip select |
| busy | output | 1 | transaction in progress |
| xfer_done | output | 1 | end-of-transaction pulse |
| tx_underrun | output | 1 | sticky flag: write byte was late |

## Verification
Every mode code is run against all four CPOL/CPHA combinations. The dividers and counts vary with the run, so each phase order is seen with single-byte and multi-byte phases at several SCK rates. A slave model in the bench returns a byte pattern that depends on position. This lets the bench tell a misplaced phase from a wrong fill value, an off-by-one count or a sampling edge that is one edge away. Two further runs hold back the transmit stream and send a second start mid-transaction; these separate stall behaviour and trigger rejection from the ordinary data path.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   typedef enum logic [2:0] {
      PH_NONE, PH_WR, PH_RD, PH_RCV, PH_DMY, PH_DUP
   } phase_e;

   typedef enum logic [2:0] {
      S_IDLE, S_LOAD, S_H1, S_H2, S_TRAIL
   } seq_state_e;

   // phase occupying slot idx for a given mode code
   function automatic phase_e phase_of(input logic [2:0] mode, input logic [1:0] idx);
      phase_e p0, p1, p2;
      p0 = PH_NONE;
      p1 = PH_NONE;
      p2 = PH_NONE;
      case (mode)
         3'd0: p0 = PH_DUP;
         3'd1: p0 = PH_WR;
         3'd2: p0 = PH_RD;
         3'd3: begin p0 = PH_WR; p1 = PH_RD; end
         3'd4: begin p0 = PH_RD; p1 = PH_WR; end
         3'd5: begin p0 = PH_WR; p1 = PH_DMY; p2 = PH_RD; end
         3'd6: begin p0 = PH_RD; p1 = PH_DMY; p2 = PH_WR; end
         default: p0 = PH_RCV;
      endcase
      case (idx)
         2'd0: return p0;
         2'd1: return p1;
         2'd2: return p2;
         default: return PH_NONE;
      endcase
   endfunction

   function automatic logic takes_tx(input phase_e p);
      return (p == PH_WR) || (p == PH_DUP);
   endfunction

   function automatic logic gives_rx(input phase_e p);
      return (p == PH_RD) || (p == PH_RCV) || (p == PH_DUP);
   endfunction

endpackage

// File: rtl/spi_seq_halftimer.sv
module spi_seq_halftimer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   // R5: the half-period counter never passes the divider
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= div));

   // R5: with a divider above zero, two ticks are never adjacent
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              cpha,
   input  logic              lead_edge,
   input  logic              trail_edge,
   input  logic              last_bit,
   input  logic              miso,
   output logic              mosi,
   output logic [BYTE_W-1:0] rx_full
);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end

   localparam int MSB = BYTE_W - 1;

   logic [BYTE_W-1:0] tx_sh, rx_sh;
   logic              mosi_r;

   assign mosi    = mosi_r;
   assign rx_full = cpha ? {rx_sh[MSB-1:0], miso} : rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         rx_sh  <= '0;
         mosi_r <= 1'b0;
      end else if (clear) begin
         mosi_r <= 1'b0;
      end else if (load) begin
         if (cpha) begin
            tx_sh <= load_data;
         end else begin
            tx_sh  <= load_data << 1;
            mosi_r <= load_data[MSB];
         end
      end else if (lead_edge) begin
         if (cpha) begin
            mosi_r <= tx_sh[MSB];
            tx_sh  <= tx_sh << 1;
         end else begin
            rx_sh <= {rx_sh[MSB-1:0], miso};
         end
      end else if (trail_edge) begin
         if (cpha) begin
            rx_sh <= {rx_sh[MSB-1:0], miso};
         end else if (!last_bit) begin
            mosi_r <= tx_sh[MSB];
            tx_sh  <= tx_sh << 1;
         end
      end
   end

   // R6: a byte load never coincides with an SCK edge
   p_load_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !(lead_edge || trail_edge));

endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
   import spi_seq_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int CNT_W  = 10,
   parameter int DMY_W  = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [CNT_W-1:0]  wr_cnt,
   input  logic [CNT_W-1:0]  rd_cnt,
   input  logic [DMY_W-1:0]  dmy_cnt,
   input  logic [DIV_W-1:0]  div,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tx_valid,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n,
   output logic              busy,
   output logic              xfer_done,
   output logic              tx_underrun
);

   if (CNT_W < DMY_W) begin : g_bad_cnt
      $error("CNT_W must not be narrower than DMY_W");
   end

   localparam int BIT_W = $clog2(BYTE_W);

   seq_state_e        state;
   logic [2:0]        cfg_mode;
   logic [CNT_W-1:0]  cfg_wr, cfg_rd;
   logic [DMY_W-1:0]  cfg_dmy;
   logic [DIV_W-1:0]  cfg_div;
   logic              cfg_cpol, cfg_cpha;
   logic [1:0]        ph_idx;
   logic [CNT_W-1:0]  byte_cnt, ph_limit;
   logic [BIT_W-1:0]  bit_cnt;
   logic              underrun_q, done_q, rxv_q;
   logic [BYTE_W-1:0] rxd_q, rx_full, fill;
   phase_e            cur_ph, next_ph;
   logic              tick, run, want_tx, stall, last_bit;
   logic              load, lead_edge, trail_edge;

   assign cur_ph  = phase_of(cfg_mode, ph_idx);
   assign next_ph = phase_of(cfg_mode, ph_idx + 2'd1);
   assign want_tx = takes_tx(cur_ph);
   assign stall   = (state == S_LOAD) && want_tx && !tx_valid;
   assign fill    = (cur_ph == PH_RCV) ? {BYTE_W{1'b1}} : '0;
   assign last_bit = (bit_cnt == BIT_W'(BYTE_W - 1));

   always_comb begin
      case (cur_ph)
         PH_RD, PH_RCV: ph_limit = cfg_rd;
         PH_DMY:        ph_limit = CNT_W'(cfg_dmy);
         default:       ph_limit = cfg_wr;
      endcase
   end

   assign run        = (state == S_H1) || (state == S_H2) || (state == S_TRAIL);
   assign load       = (state == S_LOAD) && !stall;
   assign lead_edge  = (state == S_H1) && tick;
   assign trail_edge = (state == S_H2) && tick;

   spi_seq_halftimer #(.DIV_W(DIV_W)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (cfg_div),
      .tick  (tick)
   );

   spi_seq_shifter #(.BYTE_W(BYTE_W)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (state == S_IDLE),
      .load       (load),
      .load_data  (want_tx ? tx_data : fill),
      .cpha       (cfg_cpha),
      .lead_edge  (lead_edge),
      .trail_edge (trail_edge),
      .last_bit   (last_bit),
      .miso       (miso),
      .mosi       (mosi),
      .rx_full    (rx_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cfg_mode   <= '0;
         cfg_wr     <= '0;
         cfg_rd     <= '0;
         cfg_dmy    <= '0;
         cfg_div    <= '0;
         cfg_cpol   <= 1'b0;
         cfg_cpha   <= 1'b0;
         ph_idx     <= '0;
         byte_cnt   <= '0;
         bit_cnt    <= '0;
         underrun_q <= 1'b0;
         done_q     <= 1'b0;
         rxv_q      <= 1'b0;
         rxd_q      <= '0;
      end else begin
         done_q <= 1'b0;
         rxv_q  <= 1'b0;
         case (state)
            S_IDLE: begin
               cfg_mode <= mode;
               cfg_wr   <= wr_cnt;
               cfg_rd   <= rd_cnt;
               cfg_dmy  <= dmy_cnt;
               cfg_div  <= div;
               cfg_cpol <= cpol;
               cfg_cpha <= cpha;
               if (start) begin
                  state      <= S_LOAD;
                  ph_idx     <= '0;
                  byte_cnt   <= '0;
                  bit_cnt    <= '0;
                  underrun_q <= 1'b0;
               end
            end
            S_LOAD: begin
               if (stall) underrun_q <= 1'b1;
               else       state      <= S_H1;
            end
            S_H1: if (tick) state <= S_H2;
            S_H2: if (tick) begin
               if (last_bit) begin
                  bit_cnt <= '0;
                  if (gives_rx(cur_ph)) begin
                     rxv_q <= 1'b1;
                     rxd_q <= rx_full;
                  end
                  if (byte_cnt == ph_limit) begin
                     byte_cnt <= '0;
                     if (next_ph != PH_NONE) begin
                        ph_idx <= ph_idx + 2'd1;
                        state  <= S_LOAD;
                     end else begin
                        state <= S_TRAIL;
                     end
                  end else begin
                     byte_cnt <= byte_cnt + 1'b1;
                     state    <= S_LOAD;
                  end
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
                  state   <= S_H1;
               end
            end
            S_TRAIL: if (tick) begin
               state  <= S_IDLE;
               done_q <= 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign tx_ready    = (state == S_LOAD) && want_tx;
   assign rx_valid    = rxv_q;
   assign rx_data     = rxd_q;
   assign sck         = cfg_cpol ^ (state == S_H2);
   assign cs_n        = (state == S_IDLE);
   assign busy        = (state != S_IDLE);
   assign xfer_done   = done_q;
   assign tx_underrun = underrun_q;

   // R8: the end pulse lasts one cycle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   // R8: the end pulse marks the first idle cycle after activity
   p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!busy && $past(busy)));

   // R10: a starved write keeps waiting and the flag is raised
   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !tx_valid) |=> (tx_ready && tx_underrun));

   // R2: received bytes are never back to back
   p_rx_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6: with CPHA=0, MOSI does not move inside the second half of a bit
   p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_cpha && state == S_H2 && $past(state == S_H2)) |-> $stable(mosi));

endmodule

// File: tb/spi_phase_seq_tb.sv
module spi_phase_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] mode = '0;
   logic [9:0] wr_cnt = '0, rd_cnt = '0;
   logic [2:0] dmy_cnt = '0;
   logic [7:0] div = '0;
   logic       cpol = 1'b0, cpha = 1'b0;
   logic       tx_en = 1'b1;
   logic       tx_valid, tx_ready, rx_valid, sck, mosi, cs_n, busy, xfer_done, tx_underrun;
   logic       miso = 1'b0;
   logic [7:0] tx_data, rx_data;

   int errs = 0, checks = 0;
   int cyc = 0, tx_idx = 0, done_seen = 0;
   int rx_n = 0, m_n = 0, mbits = 0, edge_n = 0, mpos = 0, gap_err = 0;
   int cs_fall_cyc = 0, cs_rise_cyc = 0, first_edge_cyc = 0, last_edge_cyc = 0;
   int cur_div = 0;
   logic tb_cpha = 1'b0, hs_prev = 1'b0, prev_sck = 1'b0, prev_cs = 1'b1;
   logic [7:0] mcap = '0;
   logic [7:0] mosi_buf [64];
   logic [7:0] rx_buf [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] txbyte(int i);
      return 8'((8'h3C + i * 29) & 8'hFF);
   endfunction

   function automatic logic [7:0] sbyte(int k);
      return 8'((8'hA5 ^ (k * 53)) & 8'hFF);
   endfunction

   function automatic logic sbit(int p);
      logic [7:0] b;
      b = sbyte(p / 8);
      return b[7 - (p % 8)];
   endfunction

   // phase codes: 1 write, 2 read, 3 receive(0xFF), 4 dummy, 5 duplex, 0 none
   function automatic int bph(int m, int i);
      int p [3];
      p = '{0, 0, 0};
      case (m)
         0: p[0] = 5;
         1: p[0] = 1;
         2: p[0] = 2;
         3: p = '{1, 2, 0};
         4: p = '{2, 1, 0};
         5: p = '{1, 4, 2};
         6: p = '{2, 4, 1};
         default: p[0] = 3;
      endcase
      return p[i];
   endfunction

   assign tx_valid = tx_en;
   assign tx_data  = txbyte(tx_idx);

   spi_phase_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .dmy_cnt(dmy_cnt), .div(div),
      .cpol(cpol), .cpha(cpha), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
      .xfer_done(xfer_done), .tx_underrun(tx_underrun)
   );

   // bench-side slave and stream observers
   always @(negedge clk) begin
      cyc++;
      if (hs_prev) tx_idx++;
      hs_prev = tx_ready && tx_valid;
      if (xfer_done) done_seen++;
      if (rx_valid && rx_n < 64) begin rx_buf[rx_n] = rx_data; rx_n++; end
      if (prev_cs && !cs_n) begin
         cs_fall_cyc = cyc; edge_n = 0; mpos = 0; mbits = 0; m_n = 0;
         if (!tb_cpha) miso = sbit(0);
      end
      if (!prev_cs && cs_n) cs_rise_cyc = cyc;
      if (!cs_n && sck !== prev_sck) begin
         edge_n++;
         if (edge_n == 1) first_edge_cyc = cyc;
         if (edge_n % 2 == 0 && cyc - last_edge_cyc != cur_div + 1) gap_err++;
         last_edge_cyc = cyc;
         if ((edge_n % 2 == 1) != tb_cpha) begin
            mcap = {mcap[6:0], mosi};
            mbits++;
            if (mbits == 8) begin
               if (m_n < 64) mosi_buf[m_n] = mcap;
               m_n++; mbits = 0;
            end
         end
         if (tb_cpha && edge_n % 2 == 1) begin miso = sbit(mpos); mpos++; end
         if (!tb_cpha && edge_n % 2 == 0) begin mpos++; miso = sbit(mpos); end
      end
      prev_sck = sck;
      prev_cs  = cs_n;
   end

   task automatic chk(input logic ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic run_xfer(input int m, input int wc, input int rc, input int dc,
                           input int dv, input logic pol, input logic pha,
                           input int stall_cyc, input logic restart);
      int tx_base, d0, w, k, r, t, nw, bad_m, bad_r, fm_a, fm_e, fr_a, fr_e;
      @(negedge clk);
      mode = 3'(m); wr_cnt = 10'(wc); rd_cnt = 10'(rc); dmy_cnt = 3'(dc);
      div = 8'(dv); cpol = pol; cpha = pha; tb_cpha = pha; cur_div = dv;
      rx_n = 0;
      tx_en = (stall_cyc == 0);
      @(negedge clk);
      @(negedge clk);
      tx_base = tx_idx; d0 = done_seen;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
      w = 0;
      while (done_seen == d0 && w < 6000) begin
         @(negedge clk);
         w++;
         if (w == stall_cyc) tx_en = 1'b1;
         if (restart && w == 30) start = 1'b1;
         if (restart && w == 31) start = 1'b0;
      end
      tx_en = 1'b1;
      chk(done_seen != d0, "R8 transaction completes", done_seen - d0, 1);
      repeat (6) @(negedge clk);
      chk(done_seen - d0 == 1, restart ? "R9 single end pulse despite second start" : "R8 single end pulse",
          done_seen - d0, 1);
      chk(busy === 1'b0 && cs_n === 1'b1, "R8 R9 idle after end", int'(busy), 0);
      chk(sck === pol, "R5 idle SCK level", int'(sck), int'(pol));
      // expected streams
      k = 0; r = 0; t = tx_base; nw = 0; bad_m = 0; bad_r = 0;
      fm_a = 0; fm_e = 0; fr_a = 0; fr_e = 0;
      for (int ph = 0; ph < 3; ph++) begin
         int code, n;
         logic [7:0] em;
         code = bph(m, ph);
         n = (code == 1 || code == 5) ? wc + 1 : (code == 4) ? dc + 1 : (code == 0) ? 0 : rc + 1;
         for (int j = 0; j < n; j++) begin
            if (code == 1 || code == 5) begin em = txbyte(t); t++; nw++; end
            else if (code == 3)         em = 8'hFF;
            else                        em = 8'h00;
            if (k < 64 && mosi_buf[k] !== em) begin
               if (bad_m == 0) begin fm_a = int'(mosi_buf[k]); fm_e = int'(em); end
               bad_m++;
            end
            if (code == 2 || code == 3 || code == 5) begin
               if (r < 64 && rx_buf[r] !== sbyte(k)) begin
                  if (bad_r == 0) begin fr_a = int'(rx_buf[r]); fr_e = int'(sbyte(k)); end
                  bad_r++;
               end
               r++;
            end
            k++;
         end
      end
      chk(m_n == k, "R1 R2 bytes on MOSI", m_n, k);
      chk(bad_m == 0, "R1 R3 R4 MOSI byte values", fm_a, fm_e);
      chk(rx_n == r, "R2 R3 received byte count", rx_n, r);
      chk(bad_r == 0, "R3 R6 received byte values", fr_a, fr_e);
      chk(edge_n == 16 * k, "R2 SCK edge count", edge_n, 16 * k);
      chk(gap_err == 0, "R5 half-period length", gap_err, 0);
      chk(tx_idx - tx_base == nw, "R1 transmit bytes taken", tx_idx - tx_base, nw);
      if (stall_cyc == 0)
         chk(first_edge_cyc - cs_fall_cyc == dv + 2, "R7 lead time", first_edge_cyc - cs_fall_cyc, dv + 2);
      chk(cs_rise_cyc - last_edge_cyc == dv + 1, "R7 trail time", cs_rise_cyc - last_edge_cyc, dv + 1);
      chk(tx_underrun === (stall_cyc != 0), "R10 underrun flag", int'(tx_underrun), int'(stall_cyc != 0));
      gap_err = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n === 1'b1 && busy === 1'b0, "R11 reset cs_n/busy", int'(cs_n), 1);
      chk(sck === 1'b0 && mosi === 1'b0, "R11 reset sck/mosi", int'(sck), 0);
      chk(tx_ready === 1'b0 && rx_valid === 1'b0 && tx_underrun === 1'b0,
          "R11 reset handshake/flag", int'(tx_ready), 0);
      for (int m = 0; m < 8; m++)
         for (int pm = 0; pm < 4; pm++)
            run_xfer(m, pm % 3, (m % 2) + (pm >> 1), pm % 2, (m + pm) % 3,
                     pm[1], pm[0], 0, 1'b0);
      // R10: starved transmit stream, data still intact; flag cleared on next start
      run_xfer(1, 2, 0, 0, 1, 1'b0, 1'b0, 25, 1'b0);
      run_xfer(5, 1, 1, 2, 0, 1'b1, 1'b1, 40, 1'b0);
      run_xfer(3, 0, 0, 0, 0, 1'b0, 1'b1, 0, 1'b0);
      // R9: second start during a transaction
      run_xfer(3, 1, 1, 0, 1, 1'b1, 1'b0, 0, 1'b1);
      run_xfer(6, 0, 2, 1, 2, 1'b0, 1'b1, 0, 1'b1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule